// File: doc/BRIEF.md
# Dual Up-Counter with Interchangeable Count Triggers

The block holds two identical, independent up-counters, each four bits wide by default. Each counter has its own trigger pair and its own clear line. A counter steps forward by one on a rising edge of its `trig_clk` input while its `trig_en` input is high. It also steps forward on a falling edge of `trig_en` while `trig_clk` is low. Because the two trigger inputs are interchangeable in this way, counters can be chained in ripple fashion: the most significant output bit of one counter drives the `trig_en` input of the next, whose `trig_clk` is tied low.

All trigger and clear inputs are treated as asynchronous levels. They pass through a two-flop synchronizer on the single system clock `clk`, and edges are found by comparing each synchronized value with the one from the cycle before. No clock is ever gated. A build parameter selects binary counting (0 to 15) or decimal counting (0 to 9). Every stage of a counter updates in the same system clock cycle.

Top module: `dual_trig_counter`

## Requirements
- R1: Counter k drives bits `cnt_q[4k+3:4k]`, with bit 4k as the least significant. Stimulus on one counter's inputs never changes the other counter's output.
- R2: A rising edge on `trig_clk` while `trig_en` is high advances that counter by exactly one.
- R3: A falling edge on `trig_en` while `trig_clk` is low advances that counter by exactly one.
- R4: A rising edge on `trig_clk` while `trig_en` is low leaves the count unchanged. A falling edge on `trig_en` while `trig_clk` is high also leaves it unchanged. With no trigger edge, the count holds.
- R5: While `trig_clr` is high, that counter reads 0 and stays at 0, whatever its trigger inputs do.
- R6: Trigger edges that occur while `trig_clr` is high are not counted after `trig_clr` returns low.
- R7: With DECIMAL=0 the count runs 0 to 15, then returns to 0.
- R8: With DECIMAL=1 the count runs 0 to 9, then returns to 0. The count never exceeds the limit of its mode.
- R9: Driving counter 1's `trig_en` from counter 0's bit 3, with counter 1's `trig_clk` held low, advances counter 1 by one each time counter 0's bit 3 falls.
- R10: `rst` (synchronous, active high) clears both counters. Input levels present when `rst` is released are not taken as edges. A qualifying trigger edge shows on `cnt_q` after the third rising `clk` edge that follows the input change.
- R11: A rising `trig_clk` and a falling `trig_en` seen in the same sample advance the counter by at most one. With the qualifying rules of R2 and R3 applied, this pair gives no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| trig_clk | input | NUM_CH | Per-counter clock-type trigger, asynchronous |
| trig_en | input | NUM_CH | Per-counter enable-type trigger, asynchronous |
| trig_clr | input | NUM_CH | Per-counter active-high clear level, asynchronous |
| cnt_q | output | NUM_CH*CNT_W | Counter values, counter k in bits [k*CNT_W +: CNT_W] |

## Verification
The bench builds the block twice from the same stimulus. One instance uses DECIMAL=0 and the other DECIMAL=1, so both wrap points (15 to 0 and 9 to 0) and both shapes of the bit-3 fall are in reach in a single run. In both instances counter 1 can be switched to take its enable from counter 0's bit 3. This exposes the ripple carry across a full binary cycle of 16 and a full decimal cycle of 10. Random trigger and clear patterns then reach the simultaneous-edge, clear-during-edge and unqualified-edge cases on top of the directed sequences.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    // Synchronized trigger levels for one counter
    typedef struct packed {
        logic clk;
        logic en;
        logic clr;
    } trig_in_t;

    // Which trigger path fired in a given sample
    typedef enum logic [1:0] {
        TRG_NONE     = 2'd0,
        TRG_CLK_RISE = 2'd1,
        TRG_EN_FALL  = 2'd2
    } trig_kind_t;

    // Highest value before the count returns to zero
    function automatic int count_limit(input int width, input bit decimal);
        if (decimal) return 9;
        return (1 << width) - 1;
    endfunction

endpackage

// File: rtl/dtc_sync.sv
module dtc_sync
    import dtc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  trig_in_t d,
    output trig_in_t q
);
    trig_in_t pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dtc_edge.sv
module dtc_edge
    import dtc_pkg::*;
#(
    parameter int WARM = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  trig_in_t   s,
    output trig_kind_t kind,
    output logic       clr_o
);
    trig_in_t        prev;
    logic [WARM-1:0] warm;
    logic            ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            warm <= '0;
        end else begin
            prev <= s;
            warm <= {warm[WARM-2:0], 1'b1};
        end
    end

    assign ready = warm[WARM-1];

    // Edges landing while clear is high are absorbed, since prev keeps tracking
    always_comb begin
        kind = TRG_NONE;
        if (ready && !s.clr) begin
            if (s.clk && !prev.clk && s.en)
                kind = TRG_CLK_RISE;
            else if (prev.en && !s.en && !s.clk)
                kind = TRG_EN_FALL;
        end
    end

    assign clr_o = s.clr;
endmodule

// File: rtl/dtc_counter.sv
module dtc_counter
    import dtc_pkg::*;
#(
    parameter int W   = 4,
    parameter bit DEC = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  trig_kind_t kind,
    input  logic       clr,
    output logic [W-1:0] q
);
    localparam int           LIM_I = count_limit(W, DEC);
    localparam logic [W-1:0] LIMIT = W'(LIM_I);

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (kind != TRG_NONE)
            q <= (q == LIMIT) ? '0 : q + 1'b1;
    end

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (kind == TRG_NONE && !clr) |=> $stable(q));

    assert_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (kind != TRG_NONE && !clr) |=> (q != $past(q)));

    assert_range_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (q <= LIMIT));
endmodule

// File: rtl/dual_trig_counter.sv
module dual_trig_counter
    import dtc_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CNT_W       = 4,
    parameter bit DECIMAL     = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       trig_clk,
    input  logic [NUM_CH-1:0]       trig_en,
    input  logic [NUM_CH-1:0]       trig_clr,
    output logic [NUM_CH*CNT_W-1:0] cnt_q
);
    localparam int WARM = SYNC_STAGES + 1;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        trig_in_t   raw;
        trig_in_t   synced;
        trig_kind_t kind;
        logic       clr_s;

        assign raw.clk = trig_clk[ch];
        assign raw.en  = trig_en[ch];
        assign raw.clr = trig_clr[ch];

        dtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw),
            .q   (synced)
        );

        dtc_edge #(.WARM(WARM)) u_edge (
            .clk   (clk),
            .rst   (rst),
            .s     (synced),
            .kind  (kind),
            .clr_o (clr_s)
        );

        dtc_counter #(.W(CNT_W), .DEC(DECIMAL)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .kind (kind),
            .clr  (clr_s),
            .q    (cnt_q[ch*CNT_W +: CNT_W])
        );
    end
endmodule

// File: tb/dual_trig_counter_tb.sv
module dual_trig_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] d_clk = '0, d_en = '0, d_clr = '0;
    logic       casc = 1'b0;
    logic [1:0] in_clk, in_en_b, in_en_d;
    logic [7:0] q_bin, q_dec;

    int checks = 0, errors = 0;
    int exp_b [2];
    int exp_d [2];

    always #10 clk = ~clk;

    assign in_clk  = {casc ? 1'b0 : d_clk[1], d_clk[0]};
    assign in_en_b = {casc ? q_bin[3] : d_en[1], d_en[0]};
    assign in_en_d = {casc ? q_dec[3] : d_en[1], d_en[0]};

    dual_trig_counter #(.DECIMAL(1'b0)) u_dut (
        .clk(clk), .rst(rst), .trig_clk(in_clk), .trig_en(in_en_b),
        .trig_clr(d_clr), .cnt_q(q_bin));

    dual_trig_counter #(.DECIMAL(1'b1)) u_dut_dec (
        .clk(clk), .rst(rst), .trig_clk(in_clk), .trig_en(in_en_d),
        .trig_clr(d_clr), .cnt_q(q_dec));

    function automatic int upd(int v, bit c0, bit c1, bit e0, bit e1, bit r, bit dec);
        int lim;
        lim = dec ? 9 : 15;
        if (r) return 0;
        if ((!c0 && c1 && e1) || (e0 && !e1 && !c1)) return (v == lim) ? 0 : v + 1;
        return v;
    endfunction

    task automatic check(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(int'(q_bin[3:0]), exp_b[0], {tag, " bin ch0"});
        check(int'(q_bin[7:4]), exp_b[1], {tag, " bin ch1"});
        check(int'(q_dec[3:0]), exp_d[0], {tag, " dec ch0"});
        check(int'(q_dec[7:4]), exp_d[1], {tag, " dec ch1"});
    endtask

    // Update the models and drive the new levels (call at a negedge)
    task automatic set_inputs(logic [1:0] nc, logic [1:0] ne, logic [1:0] nr);
        for (int dec = 0; dec < 2; dec++) begin
            int o0, n0, o1, n1;
            o0 = dec ? exp_d[0] : exp_b[0];
            o1 = dec ? exp_d[1] : exp_b[1];
            n0 = upd(o0, d_clk[0], nc[0], d_en[0], ne[0], nr[0], dec[0]);
            if (casc)
                n1 = upd(o1, 1'b0, 1'b0, o0[3], n0[3], nr[1], dec[0]);
            else
                n1 = upd(o1, d_clk[1], nc[1], d_en[1], ne[1], nr[1], dec[0]);
            if (dec) begin exp_d[0] = n0; exp_d[1] = n1; end
            else begin exp_b[0] = n0; exp_b[1] = n1; end
        end
        d_clk = nc; d_en = ne; d_clr = nr;
    endtask

    task automatic step(logic [1:0] nc, logic [1:0] ne, logic [1:0] nr, string tag);
        @(negedge clk);
        set_inputs(nc, ne, nr);
        repeat (9) @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        int old;
        exp_b = '{0, 0};
        exp_d = '{0, 0};
        void'($urandom(32'd4520));
        // R10: levels high during reset must not count as edges
        d_clk = 2'b01; d_en = 2'b01;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        check_all("R10 reset state");

        // R10 latency: count visible after the third rising clk edge
        step(2'b00, 2'b01, 2'b00, "R4 clk fall");
        @(negedge clk);
        old = exp_b[0];
        set_inputs(2'b01, 2'b01, 2'b00);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(int'(q_bin[3:0]), old, "R10 before third edge");
        @(posedge clk);
        @(negedge clk);
        check(int'(q_bin[3:0]), exp_b[0], "R10 at third edge");
        step(2'b00, 2'b01, 2'b00, "R2 settle");

        // R1, R2, R7, R8: clock pulses on ch0 only, ch1 must stay put
        for (int i = 0; i < 17; i++) begin
            step(2'b01, 2'b01, 2'b00, "R1 R2 R7 R8 clk rise");
            step(2'b00, 2'b01, 2'b00, "R1 R2 clk low");
        end

        // R3: enable falls with clk low, on ch1
        for (int i = 0; i < 11; i++) begin
            step(2'b00, 2'b11, 2'b00, "R3 en high");
            step(2'b00, 2'b01, 2'b00, "R3 R8 en fall");
        end

        // R4: unqualified edges
        step(2'b00, 2'b00, 2'b00, "R4 en low");
        step(2'b01, 2'b00, 2'b00, "R4 clk rise en low");
        step(2'b01, 2'b01, 2'b00, "R4 en rise clk high");
        step(2'b01, 2'b00, 2'b00, "R4 en fall clk high");
        step(2'b00, 2'b01, 2'b00, "R4 return");

        // R11: clk rise and en fall in the same sample
        step(2'b01, 2'b00, 2'b00, "R11 simultaneous");
        step(2'b00, 2'b01, 2'b00, "R11 return");

        // R5 and R6: clear holds and absorbs edges
        step(2'b00, 2'b01, 2'b01, "R5 clear");
        step(2'b01, 2'b01, 2'b01, "R5 R6 rise under clear");
        step(2'b01, 2'b01, 2'b00, "R6 release");
        step(2'b00, 2'b01, 2'b00, "R6 return");

        // R9: ripple cascade of ch1 from ch0 bit 3
        step(2'b00, 2'b01, 2'b11, "R9 clear both");
        @(negedge clk);
        d_en[1] = 1'b0;
        casc = 1'b1;
        step(2'b00, 2'b01, 2'b00, "R9 cascade on");
        for (int i = 0; i < 40; i++) begin
            step(2'b01, 2'b01, 2'b00, "R9 cascade rise");
            step(2'b00, 2'b01, 2'b00, "R9 cascade low");
        end
        for (int i = 0; i < 150; i++) begin
            logic [1:0] nc, ne, nr;
            nc = 2'($urandom());
            ne = 2'($urandom());
            nr = {($urandom() % 20) == 0, ($urandom() % 20) == 0};
            step(nc, ne, nr, "R5 R9 random cascade");
        end
        step(d_clk, d_en, 2'b11, "R5 clear before release");
        @(negedge clk);
        d_en[1] = 1'b0; d_clk[1] = 1'b0;
        casc = 1'b0;
        step(d_clk, d_en, 2'b00, "R1 cascade off");

        // Random patterns on both channels
        for (int i = 0; i < 300; i++) begin
            logic [1:0] nc, ne, nr;
            nc = 2'($urandom());
            ne = 2'($urandom());
            nr = {($urandom() % 16) == 0, ($urandom() % 16) == 0};
            step(nc, ne, nr, "R2 R3 R4 R11 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule